// File: doc/BRIEF.md
# Conditioned Random Word Unit

This block produces 64-bit random words for a read-random instruction. A single entropy bit arrives on every clock from an external noise source. Each bit is used in two ways:

- It is shifted into a raw collection register.
- It is folded into a one-dimensional linear hybrid cellular automaton, which spreads each bit across the word and removes bias.

A requester asks for one word at a time and picks either the raw bits or the automaton state. The unit holds the request until the chosen source has enough fresh material. It then returns the word with a one-cycle valid pulse.

If the noise source flags a fault while a request is outstanding, the unit answers at once with an all-ones word. The requester reads that word as "no random value available".

Top module: `rng_cond_unit`

## Requirements
- R1: Reset is synchronous and active-low (`rst_n`). While it is low on a clock edge, the automaton, the raw register, both fill counters and any outstanding request are cleared, and `rsp_valid` and `rsp_data` are 0.
- R2: On every clock with reset released, each automaton cell i takes the XOR of cell i-1 and cell i+1. Cells beyond either end read as 0. Where bit i of `RULE_MASK` is 1, the cell also XORs in its own value. `ent_bit` is XORed into cell 0 on top of this.
- R3: On every clock with reset released, `ent_bit` enters bit 0 of the raw register and the older bits move one place up. A raw response carries the register contents just before the response edge, so the newest bit is in bit 0.
- R4: A raw response is given only once 64 clock edges have elapsed since reset or since the last raw response edge. A raw request made earlier waits.
- R5: A conditioned response carries the automaton state just before the response edge. It is given only after the automaton has stepped at least 64 times since reset. An earlier request waits.
- R6: `req_mode` is 0 for raw and 1 for conditioned. It is captured on the edge where a request is accepted.
- R7: If `ent_err` is high on an edge while a request is outstanding, that edge returns a word of all ones, whatever the mode or fill state. An error response does not reset the raw fill count.
- R8: A request is accepted on the edge where `req_valid` is seen. The earliest response is on the following edge. `rsp_valid` is high for exactly one cycle per response.
- R9: A request presented while another is outstanding, including on the response edge itself, is ignored. It produces no response and does not change the outstanding mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_bit | input | 1 | One entropy bit per clock |
| ent_err | input | 1 | Entropy source fault flag |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 1 | 0 = raw, 1 = conditioned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | WIDTH | Random word, or all ones on fault |

## Verification
Two events can land on the same edge: the raw fill count reaching 64 and a source fault. The bench makes them coincide by raising `ent_err` in exactly the cycle before a waiting raw request would complete. It then expects an all-ones word. A second raw request must follow on the next edge with the fresh register contents, which shows the fault did not consume the collected bits. A stray conditioned request is also injected into the middle of a long raw wait. It must neither change the answer nor produce a second pulse.

// File: rtl/rng_pkg.sv
// Shared types for the random word unit.
package rng_pkg;
    typedef enum logic {
        MODE_RAW  = 1'b0,
        MODE_COND = 1'b1
    } rng_mode_e;
endpackage

// File: rtl/rng_raw_collect.sv
// Raw entropy collector: shifts one bit per clock into a W-bit register and
// counts fresh bits since reset or the last raw read, saturating at W.
// Assumes consume is a single-cycle strobe from the response logic.
module rng_raw_collect #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    input  logic         consume,
    output logic [W-1:0] word_o,
    output logic         full_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  shreg;
    logic [CW-1:0] fresh_cnt;

    // Shift register: newest bit at position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[W-2:0], bit_in};
    end

    // Fresh-bit counter, restarted by a raw read, saturating at W.
    always_ff @(posedge clk) begin
        if (!rst_n)                   fresh_cnt <= '0;
        else if (consume)             fresh_cnt <= '0;
        else if (fresh_cnt != CW'(W)) fresh_cnt <= fresh_cnt + 1'b1;
    end

    assign word_o = shreg;
    assign full_o = (fresh_cnt == CW'(W));
endmodule

// File: rtl/rng_lhca.sv
// Linear hybrid cellular automaton conditioner: W cells with null boundaries,
// rule 150 where MASK bit is set, rule 90 elsewhere, entropy XORed into cell 0.
// Steps every clock out of reset; warm_o rises after W steps.
module rng_lhca #(
    parameter int         W    = 64,
    parameter logic [W-1:0] MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    output logic [W-1:0] state_o,
    output logic         warm_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  cells;
    logic [W-1:0]  cells_nx;
    logic [CW-1:0] step_cnt;

    // Next-state per cell, boundary cells see a zero neighbour.
    for (genvar i = 0; i < W; i++) begin : g_cell
        logic lft, rgt, slf, inj;
        if (i == 0) begin : g_lo
            assign lft = 1'b0;
            assign inj = bit_in;
        end else begin : g_mid_lo
            assign lft = cells[i-1];
            assign inj = 1'b0;
        end
        if (i == W - 1) begin : g_hi
            assign rgt = 1'b0;
        end else begin : g_mid_hi
            assign rgt = cells[i+1];
        end
        assign slf         = MASK[i] & cells[i];
        assign cells_nx[i] = lft ^ rgt ^ slf ^ inj;
    end

    // Automaton state register.
    always_ff @(posedge clk) begin
        if (!rst_n) cells <= '0;
        else        cells <= cells_nx;
    end

    // Step counter for warm-up, saturating at W.
    always_ff @(posedge clk) begin
        if (!rst_n)                  step_cnt <= '0;
        else if (step_cnt != CW'(W)) step_cnt <= step_cnt + 1'b1;
    end

    assign state_o = cells;
    assign warm_o  = (step_cnt == CW'(W));
endmodule

// File: rtl/rng_resp.sv
// Request holder and response former: accepts one request at a time, waits
// for the selected source to be ready, substitutes all ones on source error.
// Assumes the sources' ready flags are registered.
module rng_resp
    import rng_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  rng_mode_e    req_mode,
    input  logic         src_err,
    input  logic         raw_full,
    input  logic [W-1:0] raw_word,
    input  logic         ca_warm,
    input  logic [W-1:0] ca_word,
    output logic         consume_o,
    output logic         pend_o,
    output rng_mode_e    mode_o,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_data
);
    logic      pend;
    rng_mode_e mode_q;
    logic      ready;
    logic      fire;

    // Readiness of the outstanding request.
    always_comb begin
        ready = src_err | ((mode_q == MODE_RAW) ? raw_full : ca_warm);
        fire  = pend & ready;
    end

    assign consume_o = fire & ~src_err & (mode_q == MODE_RAW);

    // Request acceptance; new requests are dropped while one is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            mode_q <= MODE_RAW;
        end else if (fire) begin
            pend   <= 1'b0;
        end else if (!pend && req_valid) begin
            pend   <= 1'b1;
            mode_q <= req_mode;
        end
    end

    // Response register: one-cycle pulse, word held between responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                if (src_err)                 rsp_data <= '1;
                else if (mode_q == MODE_RAW) rsp_data <= raw_word;
                else                         rsp_data <= ca_word;
            end
        end
    end

    assign pend_o = pend;
    assign mode_o = mode_q;
endmodule

// File: rtl/rng_cond_unit.sv
// Top of the random word unit: raw collector, automaton conditioner and
// response logic. The entropy bit is assumed valid on every clock.
module rng_cond_unit
    import rng_pkg::*;
#(
    parameter int             WIDTH     = 64,
    parameter logic [WIDTH-1:0] RULE_MASK = 64'hA5C3_96E1_0F3C_5A69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ent_bit,
    input  logic             ent_err,
    input  logic             req_valid,
    input  logic             req_mode,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_data
);
    logic [WIDTH-1:0] raw_word_w;
    logic [WIDTH-1:0] ca_word_w;
    logic             raw_full_w;
    logic             ca_warm_w;
    logic             consume_w;
    logic             pend_w;
    rng_mode_e        mode_w;

    rng_raw_collect #(.W(WIDTH)) u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (ent_bit),
        .consume (consume_w),
        .word_o  (raw_word_w),
        .full_o  (raw_full_w)
    );

    rng_lhca #(.W(WIDTH), .MASK(RULE_MASK)) u_ca (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (ent_bit),
        .state_o (ca_word_w),
        .warm_o  (ca_warm_w)
    );

    rng_resp #(.W(WIDTH)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mode  (rng_mode_e'(req_mode)),
        .src_err   (ent_err),
        .raw_full  (raw_full_w),
        .raw_word  (raw_word_w),
        .ca_warm   (ca_warm_w),
        .ca_word   (ca_word_w),
        .consume_o (consume_w),
        .pend_o    (pend_w),
        .mode_o    (mode_w),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );
endmodule

// File: rtl/rng_cond_chk.sv
// Property checker for the random word unit, attached by bind.
module rng_cond_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ent_err,
    input logic         rsp_valid,
    input logic [W-1:0] rsp_data,
    input logic         pending,
    input logic         mode_q,
    input logic         raw_full,
    input logic         ca_warm
);
    // R8: response valid lasts one cycle.
    assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7: fault with a request outstanding gives all ones next cycle.
    assert_err_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && ent_err) |=> (rsp_valid && rsp_data == {W{1'b1}}));

    // R4: raw request without enough fresh bits does not answer.
    assert_raw_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !mode_q && !ent_err && !raw_full) |=> !rsp_valid);

    // R5: conditioned request before warm-up does not answer.
    assert_cond_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && mode_q && !ent_err && !ca_warm) |=> !rsp_valid);

    // R9: the outstanding mode is not disturbed by later requests.
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> $stable(mode_q));
endmodule

bind rng_cond_unit rng_cond_chk #(.W(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_err   (ent_err),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .pending   (pend_w),
    .mode_q    (mode_w),
    .raw_full  (raw_full_w),
    .ca_warm   (ca_warm_w)
);

// File: tb/rng_cond_unit_tb.sv
`timescale 1ns/1ps
module rng_cond_unit_tb;
    localparam int          W    = 64;
    localparam logic [63:0] MASK = 64'hA5C3_96E1_0F3C_5A69;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ent_bit = 1'b0;
    logic         ent_err = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_mode = 1'b0;
    logic         rsp_valid;
    logic [W-1:0] rsp_data;

    int total = 0;
    int bad   = 0;
    int pat   = 0;
    int cyc   = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    rng_cond_unit #(.WIDTH(W), .RULE_MASK(MASK)) u_dut (
        .clk(clk), .rst_n(rst_n), .ent_bit(ent_bit), .ent_err(ent_err),
        .req_valid(req_valid), .req_mode(req_mode),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // Entropy pattern driver, changes away from the active edge.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (pat)
            0: ent_bit = 1'b0;
            1: ent_bit = 1'b1;
            2: ent_bit = ~ent_bit;
            default: ent_bit = lfsr[0];
        endcase
    end

    // Requirement model: state before and after every edge.
    logic [63:0] m_ca = '0, m_sr = '0, p_ca = '0, p_sr = '0;
    always @(posedge clk) begin
        logic [63:0] nx;
        logic l, r;
        p_ca = m_ca;
        p_sr = m_sr;
        if (!rst_n) begin
            m_ca = '0;
            m_sr = '0;
        end else begin
            for (int i = 0; i < 64; i++) begin
                l = 1'b0;
                r = 1'b0;
                if (i > 0)  l = m_ca[i-1];
                if (i < 63) r = m_ca[i+1];
                nx[i] = l ^ r ^ (MASK[i] & m_ca[i]);
            end
            nx[0] = nx[0] ^ ent_bit;
            m_ca = nx;
            m_sr = {m_sr[62:0], ent_bit};
        end
    end

    // Watchdog: an expired run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic m);
        req_mode  = m;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Waits for a response; optional injection of a fault or a stray request.
    task automatic wait_rsp(input int inj_at, input bit inj_err, output int lat);
        lat = 1;
        while (!rsp_valid && lat < 400) begin
            if (lat == inj_at) begin
                if (inj_err) ent_err = 1'b1;
                else begin req_mode = 1'b1; req_valid = 1'b1; end
            end
            if (lat == inj_at + 1 && !inj_err) req_valid = 1'b0;
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        int lat;
        for (int p = 0; p < 4; p++) begin
            pat = p;
            // R1: reset state
            rst_n = 1'b0; ent_err = 1'b0; req_valid = 1'b0;
            repeat (3) @(negedge clk);
            chk(rsp_valid == 1'b0 && rsp_data == '0, "R1 reset", {63'd0, rsp_valid} | rsp_data, 64'd0);
            rst_n = 1'b1;

            // R5/R2: conditioned request before warm-up waits for 64 steps
            send(1'b1);
            wait_rsp(-1, 1'b0, lat);
            chk(lat == 65, "R5 warm-up latency", 64'(lat), 64'd65);
            chk(rsp_data == p_ca, "R2 automaton word", rsp_data, p_ca);
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R8 single pulse", {63'd0, rsp_valid}, 64'd0);

            // R3/R6: raw request with a full register answers next edge
            send(1'b0);
            wait_rsp(-1, 1'b0, lat);
            chk(lat == 2, "R8 raw latency", 64'(lat), 64'd2);
            chk(rsp_data == p_sr, "R3 raw word", rsp_data, p_sr);

            // R4: raw right after a raw read waits for 64 fresh bits
            send(1'b0);
            wait_rsp(-1, 1'b0, lat);
            chk(lat == 65, "R4 raw refill", 64'(lat), 64'd65);
            chk(rsp_data == p_sr, "R4 raw word", rsp_data, p_sr);

            // R9: stray conditioned request during a raw wait is ignored
            send(1'b0);
            wait_rsp(10, 1'b0, lat);
            chk(lat == 65, "R9 raw kept latency", 64'(lat), 64'd65);
            chk(rsp_data == p_sr, "R9 raw kept data", rsp_data, p_sr);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(rsp_valid == 1'b0, "R9 no extra response", {63'd0, rsp_valid}, 64'd0);
            end

            // R5: conditioned after warm-up answers next edge
            send(1'b1);
            wait_rsp(-1, 1'b0, lat);
            chk(lat == 2 && rsp_data == p_ca, "R5 warm conditioned", rsp_data, p_ca);

            // R7: fault while raw is not ready gives all ones at once
            ent_err = 1'b1;
            send(1'b0);
            wait_rsp(-1, 1'b0, lat);
            ent_err = 1'b0;
            chk(lat == 2 && rsp_data == '1, "R7 fault word", rsp_data, '1);

            // R7: fault on the edge the raw count completes; bits not consumed
            wait_rsp(-1, 1'b0, lat);
            send(1'b0);
            wait_rsp(-1, 1'b0, lat);
            send(1'b0);
            wait_rsp(64, 1'b1, lat);
            ent_err = 1'b0;
            chk(lat == 65 && rsp_data == '1, "R7 collision", rsp_data, '1);
            send(1'b0);
            wait_rsp(-1, 1'b0, lat);
            chk(lat == 2, "R7 count kept", 64'(lat), 64'd2);
            chk(rsp_data == p_sr, "R7 raw after fault", rsp_data, p_sr);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule